// File: doc/BRIEF.md
# Bidirectional Latch/Register Bus Transceiver

This block moves 18-bit words between an A side and a B side, one storage lane per direction. Each lane has three behaviours. It can pass its input straight through (transparent). It can keep a stored word while the lane control is low (hold). It can load a new word on a rising edge of that lane's own capture strobe (register).

The A-to-B lane drives the B side. It has an active-high output enable. The B-to-A lane drives the A side. It has an active-low output enable.

Each side is modelled as an inout split into three parts: an input word, an output word and a drive flag. A low drive flag stands for high impedance, and the output word then reads zero.

The capture strobes are ordinary inputs sampled on the system clock `clk`. An edge counts as rising when the strobe is seen low at one `clk` edge and high at the next.

Each lane runs a two-state machine:
- `S_HOLD`: the last clock edge saw the lane control low. This is the reset state.
- `S_PASS`: the last clock edge saw the lane control high.

The transitions are:
- `S_HOLD` to `S_PASS` when the lane control is high at a clock edge.
- `S_PASS` to `S_HOLD` when it is low.

The storage loads on every clock edge in transparent operation, and on a detected strobe rise otherwise.

Top module: `bidir_latch_xcvr`

## Requirements
- R1: Both lanes are 18 bits wide. An active-low reset clears both stored words to zero.
- R2: While `pass_ab` is high, `b_out` equals `a_in` in the same cycle, and the stored word follows `a_in` at each clock edge.
- R3: While `pass_ab` is low and no strobe rise is seen, the stored word and `b_out` do not change, whatever `a_in` does.
- R4: While `pass_ab` is low, a `cap_ab` rise loads `a_in` into the stored word. A rise means `cap_ab` is sampled 0 at one `clk` edge and 1 at the next, and `a_in` is taken at that second edge. The new word shows on `b_out` right after that edge.
- R5: When `pass_ab` falls, the lane keeps the `a_in` value sampled at the last clock edge with `pass_ab` high.
- R6: A `cap_ab` rise that happens while `pass_ab` is high adds no capture later. If `pass_ab` then falls while `cap_ab` stays high, the word held is the last tracked one.
- R7: `b_drv` equals `oe_ab` (active high). While `oe_ab` is 0, `b_out` is all zeros.
- R8: `a_drv` equals the inverse of `oe_ba_n` (active low). While `oe_ba_n` is 1, `a_out` is all zeros. The two enables are independent, and no side is driven by this block unless its enable is active.
- R9: Capture, tracking and hold go on while a lane's output is disabled. A word captured while the output is disabled appears once the output is enabled.
- R10: The B-to-A lane follows R2 to R6, using `b_in`, `pass_ba` and `cap_ba`, and drives `a_out`.
- R11: The strobe history resets to "high". A strobe that is already high when reset ends does not capture; it must be seen low first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples strobes and updates storage |
| rst_n | input | 1 | Active-low asynchronous reset |
| a_in | input | 18 | Word present on the A side (source for A-to-B) |
| a_out | output | 18 | Word this block drives onto the A side |
| a_drv | output | 1 | A-side drive flag; 0 means high impedance |
| b_in | input | 18 | Word present on the B side (source for B-to-A) |
| b_out | output | 18 | Word this block drives onto the B side |
| b_drv | output | 1 | B-side drive flag; 0 means high impedance |
| oe_ab | input | 1 | B-side output enable, active high |
| oe_ba_n | input | 1 | A-side output enable, active low |
| pass_ab | input | 1 | A-to-B transparency control, 1 = transparent |
| pass_ba | input | 1 | B-to-A transparency control, 1 = transparent |
| cap_ab | input | 1 | A-to-B capture strobe, rising edge loads |
| cap_ba | input | 1 | B-to-A capture strobe, rising edge loads |

## Verification
Transparency and the output enables act combinationally, so their effect is due in the same cycle as the stimulus. A strobe rise, and each tracking load, land in storage at the first `clk` edge that sees the condition, and `b_out`/`a_out` show the result right after that edge. The bench sets inputs a quarter period after a rising edge. It updates its own model of each lane using the inputs held across the next edge, and compares all outputs a quarter period after that edge, so every result is read exactly one edge after its stimulus.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
    localparam int XCVR_WIDTH = 18;

    typedef enum logic {
        S_HOLD = 1'b0,
        S_PASS = 1'b1
    } lane_state_e;
endpackage

// File: rtl/xcvr_lane.sv
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = XCVR_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pass_i,
    input  logic         cap_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    lane_state_e  state, state_nx;
    logic [W-1:0] store;
    logic         cap_q;
    logic         cap_rise;
    logic         load;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_HOLD;
        end else begin
            state <= state_nx;
        end
    end

    // storage and strobe history; history resets high (R11)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            store <= '0;
            cap_q <= 1'b1;
        end else begin
            cap_q <= cap_i;
            if (load) begin
                store <= d_i;
            end
        end
    end

    // next state and outputs
    always_comb begin
        state_nx = state;
        cap_rise = cap_i & ~cap_q;
        unique case (state)
            S_PASS: begin
                if (!pass_i) state_nx = S_HOLD;
            end
            S_HOLD: begin
                if (pass_i) state_nx = S_PASS;
            end
        endcase
        load = pass_i | cap_rise;
        q_o  = pass_i ? d_i : store;
    end

    // R3: no rise possible and lane holding -> output unchanged next cycle
    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_i && !cap_i) |=> (pass_i || q_o == $past(q_o)));

    // R4: a detected rise while holding loads the sampled input
    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!pass_i && cap_i && !cap_q) |=> (pass_i || q_o == $past(d_i)));

    // R5: leaving transparency keeps the last tracked word
    a_r5_fall_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_PASS && !pass_i) |-> (q_o == $past(d_i)));
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
    parameter int W = 18
) (
    input  logic         en_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o,
    output logic         drv_o
);
    always_comb begin
        drv_o = en_i;
        q_o   = en_i ? d_i : '0;
    end
endmodule

// File: rtl/bidir_latch_xcvr.sv
module bidir_latch_xcvr
    import xcvr_pkg::*;
#(
    parameter int W = XCVR_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_in,
    output logic [W-1:0] a_out,
    output logic         a_drv,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] b_out,
    output logic         b_drv,
    input  logic         oe_ab,
    input  logic         oe_ba_n,
    input  logic         pass_ab,
    input  logic         pass_ba,
    input  logic         cap_ab,
    input  logic         cap_ba
);
    logic [W-1:0] lane_ab_q;
    logic [W-1:0] lane_ba_q;
    logic         oe_ba;

    assign oe_ba = ~oe_ba_n;

    xcvr_lane #(.W(W)) u_lane_ab (
        .clk    (clk),
        .rst_n  (rst_n),
        .pass_i (pass_ab),
        .cap_i  (cap_ab),
        .d_i    (a_in),
        .q_o    (lane_ab_q)
    );

    xcvr_lane #(.W(W)) u_lane_ba (
        .clk    (clk),
        .rst_n  (rst_n),
        .pass_i (pass_ba),
        .cap_i  (cap_ba),
        .d_i    (b_in),
        .q_o    (lane_ba_q)
    );

    xcvr_drive #(.W(W)) u_drive_b (
        .en_i  (oe_ab),
        .d_i   (lane_ab_q),
        .q_o   (b_out),
        .drv_o (b_drv)
    );

    xcvr_drive #(.W(W)) u_drive_a (
        .en_i  (oe_ba),
        .d_i   (lane_ba_q),
        .q_o   (a_out),
        .drv_o (a_drv)
    );

    // R2: transparent and enabled -> B side shows A input
    a_r2_pass_through: assert property (@(posedge clk) disable iff (!rst_n)
        (oe_ab && pass_ab) |-> (b_out == a_in && b_drv));

    // R7: B side floats when its enable is low
    a_r7_b_float: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_ab |-> (!b_drv && b_out == '0));

    // R8: A side floats when its active-low enable is high
    a_r8_a_float: assert property (@(posedge clk) disable iff (!rst_n)
        oe_ba_n |-> (!a_drv && a_out == '0));

    // R10: reverse lane transparent and enabled -> A side shows B input
    a_r10_rev_pass: assert property (@(posedge clk) disable iff (!rst_n)
        (!oe_ba_n && pass_ba) |-> (a_out == b_in && a_drv));
endmodule

// File: tb/bidir_latch_xcvr_test.sv
module bidir_latch_xcvr_test;
    localparam int P = 10;
    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_drv, b_drv;
    logic         oe_ab = 1'b1, oe_ba_n = 1'b0;
    logic         pass_ab = 1'b0, pass_ba = 1'b0;
    logic         cap_ab = 1'b1, cap_ba = 1'b0;

    int n_chk = 0;
    int n_fail = 0;
    logic [W-1:0] m_ab, m_ba;
    logic         p_ab, p_ba;

    always #(P/2) clk = ~clk;

    bidir_latch_xcvr #(.W(W)) uut (
        .clk(clk), .rst_n(rst_n),
        .a_in(a_in), .a_out(a_out), .a_drv(a_drv),
        .b_in(b_in), .b_out(b_out), .b_drv(b_drv),
        .oe_ab(oe_ab), .oe_ba_n(oe_ba_n),
        .pass_ab(pass_ab), .pass_ba(pass_ba),
        .cap_ab(cap_ab), .cap_ba(cap_ba)
    );

    task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock edge: update model from inputs held across the edge, then compare
    task automatic cyc(string tag_ab, string tag_ba);
        logic [W-1:0] eb, ea;
        @(posedge clk);
        if (pass_ab) m_ab = a_in;
        else if (cap_ab && !p_ab) m_ab = a_in;
        p_ab = cap_ab;
        if (pass_ba) m_ba = b_in;
        else if (cap_ba && !p_ba) m_ba = b_in;
        p_ba = cap_ba;
        #(P/4);
        eb = oe_ab ? (pass_ab ? a_in : m_ab) : '0;
        ea = !oe_ba_n ? (pass_ba ? b_in : m_ba) : '0;
        chk(tag_ab, b_out, eb);
        chk(tag_ba, a_out, ea);
        chk("R7", {{(W-1){1'b0}}, b_drv}, {{(W-1){1'b0}}, oe_ab});
        chk("R8", {{(W-1){1'b0}}, a_drv}, {{(W-1){1'b0}}, ~oe_ba_n});
    endtask

    initial begin
        #(P * 100000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        m_ab = '0; m_ba = '0; p_ab = 1'b1; p_ba = 1'b1;
        a_in = 18'h2A5A5; b_in = 18'h15A5A;
        repeat (3) @(posedge clk);
        #(P/4);
        rst_n = 1'b1;
        // R1: storage cleared, held lanes show zero
        cyc("R1", "R1");
        // R11: strobe high since reset does not capture
        a_in = 18'h3FFFF;
        cyc("R11", "R1");
        cyc("R11", "R1");
        // R4: low then high captures
        cap_ab = 1'b0; cyc("R4", "R1");
        cap_ab = 1'b1; a_in = 18'h12345; cyc("R4", "R1");
        chk("R4", b_out, 18'h12345);
        // R3: held while strobe constant
        a_in = 18'h00F0F; cyc("R3", "R1");
        cap_ab = 1'b0; a_in = 18'h3C3C3; cyc("R3", "R1");
        chk("R3", b_out, 18'h12345);
        // R2: transparent
        pass_ab = 1'b1; a_in = 18'h0BEEF; cyc("R2", "R1");
        chk("R2", b_out, 18'h0BEEF);
        a_in = 18'h2CAFE; cyc("R2", "R1");
        // R5: falling control keeps last tracked value
        pass_ab = 1'b0; cyc("R5", "R1");
        a_in = 18'h01111; cyc("R5", "R1");
        chk("R5", b_out, 18'h2CAFE);
        // R6: rise while transparent gives no later capture
        pass_ab = 1'b1; cap_ab = 1'b0; cyc("R6", "R1");
        cap_ab = 1'b1; a_in = 18'h0AAAA; cyc("R6", "R1");
        pass_ab = 1'b0; a_in = 18'h05555; cyc("R6", "R1");
        cyc("R6", "R1");
        chk("R6", b_out, 18'h0AAAA);
        // R7 / R9: capture with output disabled, then enable
        oe_ab = 1'b0; cap_ab = 1'b0; cyc("R7", "R1");
        cap_ab = 1'b1; a_in = 18'h13579; cyc("R7", "R1");
        oe_ab = 1'b1; a_in = 18'h02468; cyc("R9", "R1");
        chk("R9", b_out, 18'h13579);
        // R8 / R10: reverse lane
        oe_ba_n = 1'b1; cap_ba = 1'b0; cyc("R3", "R8");
        cap_ba = 1'b1; b_in = 18'h3ACE1; cyc("R3", "R8");
        oe_ba_n = 1'b0; b_in = 18'h00001; cyc("R3", "R10");
        chk("R10", a_out, 18'h3ACE1);
        pass_ba = 1'b1; b_in = 18'h22222; cyc("R3", "R10");
        chk("R10", a_out, 18'h22222);
        pass_ba = 1'b0; b_in = 18'h11111; cyc("R3", "R10");
        chk("R10", a_out, 18'h22222);
        // sweep over all control combinations with random data
        for (int i = 0; i < 2048; i++) begin
            string tab;
            {pass_ab, cap_ab, oe_ab, pass_ba, cap_ba, oe_ba_n} = 6'(i ^ (i >> 3));
            if (i[1:0] == 2'b00) begin
                pass_ab = 1'b0; pass_ba = 1'b0;
            end
            a_in = W'($urandom);
            b_in = W'($urandom);
            tab = pass_ab ? "R2" : ((cap_ab && !p_ab) ? "R4" : "R3");
            cyc(tab, "R10");
        end
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule